// File: doc/BRIEF.md
# Serial Display PHY Bring-Up Sequencer

This block brings a multi-lane serial display PHY out of power-down in a fixed order. After reset, and between sequences, it holds the PHY in shutdown and in reset. A start request loads the active lane count and the escape-clock divider into their output fields. It then pulses a request to the neighbouring register-writer block, which loads the PHY's configuration list. The PHY stays in shutdown until that block reports that it has finished.

Once configuration is done, the sequencer releases shutdown and reset. It then waits in two ordered steps: first for the PLL-lock status, then for every lane to report the stop state. Each wait has its own cycle counter with a limit taken from an input. If a limit expires, the sequencer raises an error and puts the PHY back into shutdown and reset. If both waits succeed, it raises ready. Both status inputs are asynchronous to the block clock, so each passes through a two-flop synchronizer before the state machine looks at it.

Top module: `phy_bringup_seq`

## Requirements
- R1: During and after reset, the shutdown and reset controls are both low (asserted), ready, error and the configuration request are low, and the lane-count and divider fields are 0.
- R2: A start accepted from idle loads the lane-count field (2 bits, value NUM_LANES-1 = 3) and the escape-clock divider field (8 bits, value 9). Both are visible in the cycle after start is sampled.
- R3: The configuration request is high for exactly one cycle, in the cycle after start is accepted. Shutdown and reset stay asserted from then until the done input is sampled high.
- R4: Shutdown and reset both go high (released) in the cycle after the done input is sampled high during the configuration wait, and not earlier.
- R5: Each status input must be held for two clock edges before the state machine acts on it (a two-flop synchronizer on the PLL-lock input and on each lane's stop input).
- R6: The all-lanes-stop status has no effect until the PLL lock has been seen. After lock is seen, the block waits for all lanes to stop and then raises ready.
- R7: In either wait, let the count of cycles already spent in that wait be c, starting at 0. If c reaches the limit input for that wait and the awaited status has not been seen, the block enters error: error is high, ready is low, and shutdown and reset are asserted.
- R8: If the awaited status is seen in the same cycle that the count reaches the limit, the status wins and no error is raised.
- R9: Ready stays high, whatever the status inputs do, until the next start or reset.
- R10: A start while ready or in error restarts the whole sequence, including a new configuration request. A start while a sequence is in progress is ignored.
- R11: The stop wait completes only when every lane reports stop. If one lane is missing, the stop wait times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start the bring-up sequence |
| cfg_done_i | input | 1 | Register-writer reports its configuration list is written |
| lock_limit_i | input | TMO_W | Cycle limit for the PLL-lock wait |
| stop_limit_i | input | TMO_W | Cycle limit for the lane-stop wait |
| pll_lock_i | input | 1 | PLL locked status from the PHY (asynchronous) |
| lane_stop_i | input | NUM_LANES | Per-lane stop-state status (asynchronous) |
| phy_shutdown_no | output | 1 | PHY shutdown control, low = shut down |
| phy_rst_no | output | 1 | PHY reset control, low = in reset |
| lane_cnt_o | output | 2 | Active lane count minus one |
| esc_div_o | output | ESC_W | Escape-clock divider |
| cfg_start_o | output | 1 | One-cycle request to the register-writer |
| ready_o | output | 1 | Bring-up finished |
| error_o | output | 1 | A wait timed out; PHY is held in shutdown |

## Verification
In a wait state, the arrival of the awaited status and the expiry of that state's counter can fall in the same cycle. The bench provokes this by driving the lock input exactly two edges before the counter equals its limit, so that the synchronized status and the limit reach the state machine together. It expects the sequence to move on to the stop wait with no error. It then repeats the case with the lock input one cycle later and expects error. A cycle-by-cycle reference model in the bench judges both cases, with explicit checks of error and of the shutdown control.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_CFG,
    ST_LOCK,
    ST_STOP,
    ST_READY,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/phy_status_sync.sv
module phy_status_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  // cleared whenever its wait state is not active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int TMO_W       = 16,
  parameter int ESC_W       = 8,
  parameter int ESC_DIV     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 cfg_done_i,
  input  logic [TMO_W-1:0]     lock_limit_i,
  input  logic [TMO_W-1:0]     stop_limit_i,
  input  logic                 pll_lock_i,
  input  logic [NUM_LANES-1:0] lane_stop_i,
  output logic                 phy_shutdown_no,
  output logic                 phy_rst_no,
  output logic [1:0]           lane_cnt_o,
  output logic [ESC_W-1:0]     esc_div_o,
  output logic                 cfg_start_o,
  output logic                 ready_o,
  output logic                 error_o
);
  localparam int LANE_W = 2;
  localparam logic [LANE_W-1:0] LANE_VAL = LANE_W'(NUM_LANES - 1);
  localparam logic [ESC_W-1:0]  DIV_VAL  = ESC_W'(ESC_DIV);

  seq_state_e state_q, state_d;
  logic [NUM_LANES-1:0] lane_stop_s;
  logic lock_s, all_stop_s;
  logic lock_exp, stop_exp;
  logic load_cfg;
  logic [LANE_W-1:0] lane_cnt_q;
  logic [ESC_W-1:0]  esc_div_q;

  phy_status_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pll_lock_i),
    .q_o   (lock_s)
  );

  phy_status_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_stop_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lane_stop_i),
    .q_o   (lane_stop_s)
  );

  assign all_stop_s = &lane_stop_s;

  phy_wait_timer #(.CNT_W(TMO_W)) u_lock_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_LOCK),
    .limit_i  (lock_limit_i),
    .expired_o(lock_exp)
  );

  phy_wait_timer #(.CNT_W(TMO_W)) u_stop_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_STOP),
    .limit_i  (stop_limit_i),
    .expired_o(stop_exp)
  );

  always_comb begin
    state_d  = state_q;
    load_cfg = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_READY, ST_FAULT: begin
        if (start_i) begin
          state_d  = ST_KICK;
          load_cfg = 1'b1;
        end
      end
      ST_KICK: state_d = ST_CFG;
      ST_CFG:  if (cfg_done_i) state_d = ST_LOCK;
      // status has priority over an expiring counter
      ST_LOCK: begin
        if (lock_s)        state_d = ST_STOP;
        else if (lock_exp) state_d = ST_FAULT;
      end
      ST_STOP: begin
        if (all_stop_s)    state_d = ST_READY;
        else if (stop_exp) state_d = ST_FAULT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lane_cnt_q <= '0;
      esc_div_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_cfg) begin
        lane_cnt_q <= LANE_VAL;
        esc_div_q  <= DIV_VAL;
      end
    end
  end

  logic phy_on;
  assign phy_on          = (state_q == ST_LOCK) || (state_q == ST_STOP) || (state_q == ST_READY);
  assign phy_shutdown_no = phy_on;
  assign phy_rst_no      = phy_on;
  assign cfg_start_o     = (state_q == ST_KICK);
  assign ready_o         = (state_q == ST_READY);
  assign error_o         = (state_q == ST_FAULT);
  assign lane_cnt_o      = lane_cnt_q;
  assign esc_div_o       = esc_div_q;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int NUM_LANES = 4,
  parameter int ESC_W     = 8,
  parameter int ESC_DIV   = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cfg_done_i,
  input logic             phy_shutdown_no,
  input logic             phy_rst_no,
  input logic [1:0]       lane_cnt_o,
  input logic [ESC_W-1:0] esc_div_o,
  input logic             cfg_start_o,
  input logic             ready_o,
  input logic             error_o
);
  AST_CFG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_start_o |=> !cfg_start_o); // R3

  AST_SHUT_DURING_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_start_o |-> (!phy_shutdown_no && !phy_rst_no)); // R3

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_shutdown_no) |-> $past(cfg_done_i)); // R4

  AST_FAULT_SHUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!phy_shutdown_no && !phy_rst_no && !ready_o)); // R7

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o); // R9

  AST_FIELDS_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (lane_cnt_o == 2'(NUM_LANES - 1) && esc_div_o == ESC_W'(ESC_DIV))); // R2
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
  .NUM_LANES(NUM_LANES), .ESC_W(ESC_W), .ESC_DIV(ESC_DIV)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .cfg_done_i     (cfg_done_i),
  .phy_shutdown_no(phy_shutdown_no),
  .phy_rst_no     (phy_rst_no),
  .lane_cnt_o     (lane_cnt_o),
  .esc_div_o      (esc_div_o),
  .cfg_start_o    (cfg_start_o),
  .ready_o        (ready_o),
  .error_o        (error_o)
);

// File: tb/test_phy_bringup_seq.sv
`timescale 1ns/1ps
module test_phy_bringup_seq;
  localparam int NL = 4;
  localparam int TW = 16;
  localparam int EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfg_done = 1'b0, pll_lock = 1'b0;
  logic [TW-1:0] lock_lim = 16'd20, stop_lim = 16'd20;
  logic [NL-1:0] lane_stop = '0;
  logic shut_n, prst_n, cfg_start, ready, err;
  logic [1:0] lane_cnt;
  logic [EW-1:0] esc_div;

  int compared = 0, mismatched = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  phy_bringup_seq i_phy_bringup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_done_i(cfg_done),
    .lock_limit_i(lock_lim), .stop_limit_i(stop_lim), .pll_lock_i(pll_lock),
    .lane_stop_i(lane_stop), .phy_shutdown_no(shut_n), .phy_rst_no(prst_n),
    .lane_cnt_o(lane_cnt), .esc_div_o(esc_div), .cfg_start_o(cfg_start),
    .ready_o(ready), .error_o(err)
  );

  // reference model: 0 idle 1 kick 2 cfg 3 lock 4 stop 5 ready 6 fault
  int m_st = 0, m_cnt = 0;
  logic [1:0] m_lane = '0;
  logic [EW-1:0] m_div = '0;
  bit l1 = 0, l2 = 0, s1 = 0, s2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lane = '0; m_div = '0;
      l1 = 0; l2 = 0; s1 = 0; s2 = 0;
    end else begin
      int nx;
      nx = m_st;
      case (m_st)
        0, 5, 6: if (start) begin nx = 1; m_lane = 2'(NL - 1); m_div = 8'd9; end
        1: nx = 2;
        2: if (cfg_done) nx = 3;
        3: if (l2) nx = 4; else if (m_cnt >= int'(lock_lim)) nx = 6;
        4: if (s2) nx = 5; else if (m_cnt >= int'(stop_lim)) nx = 6;
        default: nx = 0;
      endcase
      if (nx != m_st) m_cnt = 0;
      else if (m_st == 3 || m_st == 4) m_cnt++;
      m_st = nx;
      l2 = l1; l1 = pll_lock;
      s2 = s1; s1 = &lane_stop;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit on;
    on = (m_st >= 3 && m_st <= 5);
    cmp(phase, "shutdown_n", int'(shut_n), int'(on));
    cmp(phase, "phy_rst_n", int'(prst_n), int'(on));
    cmp(phase, "cfg_start", int'(cfg_start), int'(m_st == 1));
    cmp(phase, "ready", int'(ready), int'(m_st == 5));
    cmp(phase, "error", int'(err), int'(m_st == 6));
    cmp(phase, "lane_cnt", int'(lane_cnt), int'(m_lane));
    cmp(phase, "esc_div", int'(esc_div), int'(m_div));
  end

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic do_cfg();
    @(negedge clk) cfg_done = 1'b1;
    @(negedge clk) cfg_done = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "reset shutdown_n", int'(shut_n), 0);
    cmp("R1", "reset lane_cnt", int'(lane_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // normal sequence, lanes stop before lock
    phase = "R2";
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cmp("R2", "lane_cnt", int'(lane_cnt), 3);
    cmp("R2", "esc_div", int'(esc_div), 9);
    cmp("R3", "cfg_start pulse", int'(cfg_start), 1);
    phase = "R3";
    @(negedge clk) start = 1'b1;   // busy start ignored (R10)
    @(negedge clk) start = 1'b0;
    cmp("R10", "busy start cfg_start", int'(cfg_start), 0);
    cmp("R3", "shutdown during cfg", int'(shut_n), 0);
    phase = "R4";
    do_cfg();
    cmp("R4", "released", int'(shut_n), 1);
    phase = "R6";
    lane_stop = '1;
    repeat (10) @(negedge clk);
    cmp("R6", "no ready before lock", int'(ready), 0);
    cmp("R5", "no fault yet", int'(err), 0);
    pll_lock = 1'b1;
    @(negedge clk);
    cmp("R5", "lock not yet seen", int'(ready), 0);
    repeat (4) @(negedge clk);
    cmp("R6", "ready", int'(ready), 1);
    phase = "R9";
    pll_lock = 1'b0; lane_stop = '0;
    repeat (6) @(negedge clk);
    cmp("R9", "ready held", int'(ready), 1);

    // restart from ready, lock timeout
    phase = "R7";
    lock_lim = 16'd8;
    do_start();
    cmp("R10", "restart cfg_start", int'(cfg_start), 1);
    do_cfg();
    repeat (12) @(negedge clk);
    cmp("R7", "lock timeout error", int'(err), 1);
    cmp("R7", "shut in error", int'(shut_n), 0);

    // restart from error, one lane missing
    phase = "R11";
    stop_lim = 16'd8;
    do_start();
    cmp("R10", "restart from error", int'(cfg_start), 1);
    do_cfg();
    pll_lock = 1'b1; lane_stop = 4'b0111;
    repeat (20) @(negedge clk);
    cmp("R11", "stop timeout error", int'(err), 1);

    // status arrives the cycle the counter hits the limit
    phase = "R8";
    pll_lock = 1'b0; lane_stop = '0;
    lock_lim = 16'd6; stop_lim = 16'd30;
    do_start();
    do_cfg();
    repeat (6 - 2) @(posedge clk);
    @(negedge clk) pll_lock = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R8", "no error at limit", int'(err), 0);
    cmp("R8", "still released", int'(shut_n), 1);
    lane_stop = '1;
    repeat (4) @(negedge clk);
    cmp("R8", "ready after tie", int'(ready), 1);

    // one cycle late
    pll_lock = 1'b0; lane_stop = '0;
    do_start();
    do_cfg();
    repeat (6 - 1) @(posedge clk);
    @(negedge clk) pll_lock = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R8", "late lock errors", int'(err), 1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule